// File: doc/BRIEF.md
# Secure-Gated Interrupt Group Modifier Bank

This block keeps one group-modifier bit per interrupt for the extended interrupt range of a single redistributor. The bits are grouped into 32-bit registers. A memory-mapped port reads and writes them, and every access carries a secure or non-secure attribute. Each modifier bit is combined with the matching group-status bit, which arrives from outside as an input vector, to produce a decoded group class for every implemented interrupt.

Access is gated by three things: the requester's security state, a global security-disable flag, and the affinity-routing enable. Bits for unimplemented interrupts, unmapped offsets and a build without the extended range all read as zero and drop writes. The reserved encoding folds into the non-secure group 1 class.

Top module: `grpmod_bank`

## Requirements
- R1: Register n is at byte offset 0x0D00 + 4*n of the frame, for n below NUM_REGS. Only word-aligned offsets match.
- R2: After reset every modifier bit is 0, rd_valid is 0 and rd_data is 0.
- R3: A read request accepted on a clock edge gives rd_valid high with its data on the next edge. rd_valid is high only in that case.
- R4: grp_class[2m+1:2m] encodes interrupt m as follows: 2'b00 is secure group 0 (modifier 0, status 0), 2'b01 is non-secure group 1 (modifier 0, status 1), and 2'b10 is secure group 1 (modifier 1, status 0).
- R5: When both the modifier and the status bit are 1, the class is 2'b01, the same as non-secure group 1.
- R6: When sec_disable is 0, non-secure reads return 0 and non-secure writes are ignored. When sec_disable is 1, non-secure accesses behave like secure ones.
- R7: When affinity_en is 0, reads return 0, writes are ignored, and the decode treats every modifier bit as 0.
- R8: Bits for interrupts at or above NUM_IRQ read as 0 and ignore writes.
- R9: With EXT_PRESENT = 0, every read returns 0, writes are ignored, and every modifier counts as 0.
- R10: Reads of unmapped or misaligned offsets return 0 and writes to them change nothing. There is no error response.
- R11: Interrupt m is held in register m/32, bit m%32.
- R12: A write changes grp_class from the clock edge on which it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Secure attribute of the access |
| req_addr | input | ADDR_W | Byte offset within the frame |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| sec_disable | input | 1 | Global security-disable flag |
| affinity_en | input | 1 | Affinity routing enabled |
| grp_status | input | NUM_IRQ | Group-status bit per interrupt |
| grp_class | output | 2*NUM_IRQ | Decoded class per interrupt |

## Verification
The decode is driven with a status vector that mixes ones and zeros, against modifier words of alternating, sparse and all-ones patterns. This covers all four {modifier, status} pairs, so the reserved pair is told apart from the three real classes. The same write and read pairs are repeated under secure, non-secure, security-disabled and routing-disabled settings, which separates each gate from the others. Read-back after a dropped access shows the stored word did not change. Single-bit writes into the upper register show that the interrupt index maps to the right register and bit. A second instance built without the extended range must return zero for the same traffic.

// File: rtl/grpmod_bank.sv
module grpmod_bank #(
  parameter int NUM_REGS = 2,
  parameter int NUM_IRQ = 48,
  parameter int EXT_PRESENT = 1,
  parameter int ADDR_W = 16,
  parameter logic [15:0] BASE_OFF = 16'h0D00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_secure,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  input  logic                 sec_disable,
  input  logic                 affinity_en,
  input  logic [NUM_IRQ-1:0]   grp_status,
  output logic [2*NUM_IRQ-1:0] grp_class
);
  localparam int TOTAL = NUM_REGS * 32;
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_REGS * 4);
  localparam bit EXT_ON = (EXT_PRESENT != 0);

  logic [TOTAL-1:0]  mod_q;
  logic [TOTAL-1:0]  impl_mask;
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic              in_frame, ok, is_rd, wr_en;
  logic [31:0]       rd_word;

  assign off      = req_addr - BASE;
  assign in_frame = (req_addr >= BASE) && (off < SPAN) && (off[1:0] == 2'b00);
  assign idx      = off[IDX_W+1:2];
  assign ok       = EXT_ON && affinity_en && (sec_disable || req_secure) && in_frame;
  assign is_rd    = req_valid && !req_write;
  assign wr_en    = req_valid && req_write && ok;

  for (genvar g = 0; g < TOTAL; g++) begin : g_mask
    assign impl_mask[g] = (g < NUM_IRQ);
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        mod_q[r*32 +: 32] <= '0;
      else if (wr_en && idx == IDX_W'(r))
        mod_q[r*32 +: 32] <= req_wdata & impl_mask[r*32 +: 32];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (idx == IDX_W'(r)) rd_word = mod_q[r*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= is_rd;
      rd_data  <= (is_rd && ok) ? rd_word : '0;
    end
  end

  for (genvar m = 0; m < NUM_IRQ; m++) begin : g_dec
    logic eff;
    assign eff = EXT_ON && affinity_en && mod_q[m];
    assign grp_class[2*m +: 2] = {eff & ~grp_status[m], grp_status[m]};

    AST_RESERVED_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (affinity_en && mod_q[m] && grp_status[m]) |-> grp_class[2*m +: 2] == 2'b01); // R5
  end

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rd_valid); // R3
  AST_RD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(is_rd)); // R3
  AST_NS_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !req_secure && !sec_disable) |=> rd_data == '0); // R6
  AST_NS_WI: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_secure && !sec_disable) |=> $stable(mod_q)); // R6
  AST_NOAFF_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !affinity_en) |=> rd_data == '0); // R7
  AST_UNIMPL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q & ~impl_mask) == '0); // R8
endmodule

// File: tb/sim_grpmod_bank.sv
module sim_grpmod_bank;
  localparam int PERIOD = 10;
  localparam int N = 48;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_secure = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic sec_disable = 0, affinity_en = 1;
  logic [N-1:0] grp_status = 48'h3C3C_0F0F_F0F0;
  logic rd_valid, rd_valid1;
  logic [31:0] rd_data, rd_data1;
  logic [2*N-1:0] grp_class, grp_class1;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  grpmod_bank u0 (.clk, .rst_n, .req_valid, .req_write, .req_secure, .req_addr, .req_wdata,
    .rd_valid, .rd_data, .sec_disable, .affinity_en, .grp_status, .grp_class);

  grpmod_bank #(.EXT_PRESENT(0)) u1 (.clk, .rst_n, .req_valid, .req_write, .req_secure,
    .req_addr, .req_wdata, .rd_valid(rd_valid1), .rd_data(rd_data1), .sec_disable,
    .affinity_en, .grp_status, .grp_class(grp_class1));

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] model_class(logic [63:0] md, logic aff, logic [N-1:0] st);
    logic [2*N-1:0] c;
    for (int m = 0; m < N; m++) begin
      logic b;
      b = md[m] & aff;
      c[2*m +: 2] = st[m] ? 2'b01 : (b ? 2'b10 : 2'b00);
    end
    return c;
  endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d, logic sec);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_secure = sec; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [15:0] a, logic sec, logic [31:0] exp, string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_secure = sec; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
    if (rst_n && rd_valid1) check("R9 absent range reads zero", rd_data1, 0);
  end

  initial begin
    repeat (50000) @(posedge clk);
    check("watchdog expired", 1, 0);
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] md;
    repeat (3) @(negedge clk);
    check("R2 rd_valid at reset", rd_valid, 0);
    check("R2 rd_data at reset", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    check("R2 class after reset", grp_class, model_class(0, 1, grp_status));
    rd(16'h0D00, 1, 0, "R2 reg0 resets to zero");
    rd(16'h0D04, 1, 0, "R2 reg1 resets to zero");

    md = 64'h0000_FFFF_A5A5_F00F;
    wr(16'h0D00, 32'hA5A5_F00F, 1);
    check("R12 class right after write", grp_class, model_class({32'h0, md[31:0]}, 1, grp_status));
    wr(16'h0D04, 32'hFFFF_FFFF, 1);
    check("R4 R5 decode mixed patterns", grp_class, model_class(md, 1, grp_status));
    rd(16'h0D00, 1, 32'hA5A5_F00F, "R1 reg0 readback");
    rd(16'h0D04, 1, 32'h0000_FFFF, "R8 unimplemented bits read zero");
    @(negedge clk);
    req_valid = 1; req_secure = 1; req_addr = 16'h0D04;
    exp_q.push_back(32'h0000_FFFF); tag_q.push_back("R3 back-to-back first");
    @(negedge clk);
    req_addr = 16'h0D00;
    exp_q.push_back(32'hA5A5_F00F); tag_q.push_back("R3 back-to-back second");
    @(negedge clk);
    req_valid = 0;

    wr(16'h0D00, 32'h1234_5678, 0);
    rd(16'h0D00, 1, 32'hA5A5_F00F, "R6 non-secure write ignored");
    rd(16'h0D00, 0, 0, "R6 non-secure read is zero");
    sec_disable = 1;
    wr(16'h0D00, 32'h0000_00F0, 0);
    md[31:0] = 32'h0000_00F0;
    rd(16'h0D00, 0, 32'h0000_00F0, "R6 non-secure allowed when disabled");
    sec_disable = 0;

    affinity_en = 0;
    @(negedge clk);
    check("R7 decode ignores modifiers", grp_class, model_class(md, 0, grp_status));
    wr(16'h0D00, 32'hFFFF_FFFF, 1);
    rd(16'h0D00, 1, 0, "R7 read zero without routing");
    affinity_en = 1;
    rd(16'h0D00, 1, 32'h0000_00F0, "R7 write dropped without routing");

    wr(16'h0D08, 32'hFFFF_FFFF, 1);
    wr(16'h0D02, 32'hFFFF_FFFF, 1);
    rd(16'h0D08, 1, 0, "R10 unmapped offset reads zero");
    rd(16'h0D01, 1, 0, "R10 misaligned offset reads zero");
    rd(16'h0C00, 1, 0, "R10 below base reads zero");
    rd(16'h0D00, 1, 32'h0000_00F0, "R10 reg0 unchanged");
    rd(16'h0D04, 1, 32'h0000_FFFF, "R10 reg1 unchanged");

    grp_status = '0;
    wr(16'h0D04, 32'h0000_0020, 1);
    check("R11 irq37 is secure group 1", grp_class[75:74], 2'b10);
    check("R11 irq36 stays group 0", grp_class[73:72], 2'b00);
    check("R4 irq4 secure group 1", grp_class[9:8], 2'b10);
    check("R4 irq0 secure group 0", grp_class[1:0], 2'b00);
    grp_status[37] = 1;
    @(negedge clk);
    check("R5 reserved pair folds", grp_class[75:74], 2'b01);
    check("R9 absent range decode", grp_class1, model_class(0, 1, grp_status));

    repeat (3) @(negedge clk);
    check("R3 all reads answered", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule